// File: doc/BRIEF.md
# Twin-Predicated Element Step Sequencer

This block walks the element loop of one vector operation under two independent predicate masks, one for the source side and one for the destination side. A start pulse loads the vector length, a starting source step, a starting destination step, the two masks and a destination-zeroing flag. The sequencer then hands out one element operation per accepted handshake: a source index, a destination index, and a flag that says whether the result is stored as computed or stored as zero.

The two step counters move independently. Each one skips the elements its own mask disables, which gives compression (sparse source, dense destination), expansion (dense source, sparse destination) and arbitrary combined remapping. With destination zeroing on, the destination side stops skipping; masked-off destination slots still take an operation, and that operation is flagged to store zero. The loop ends as soon as either side runs past the vector length. A one-cycle done pulse then carries the step values the loop stopped at. Feeding those values back as starting steps resumes an interrupted loop.

The block does not fetch masks, touch any register file, or do the element arithmetic.

Top module: `twinpred_seq`

## Requirements
- R1: Every emitted source index has its source mask bit set (bit i of the source mask belongs to element i), and successive source indices within one loop strictly increase, so every disabled source element is skipped.
- R2: With zeroing off, every emitted destination index has its destination mask bit set, and disabled destination elements are skipped. With zeroing on, the destination index visits every element from its starting step upward.
- R3: Operations pair the current source step with the current destination step in order. The loop ends, with no further operation, once either step has no enabled element below the vector length. Examples: source mask 0b101, all-ones destination mask and length 3 give (0,0),(2,1); all-ones source mask, destination mask 0b101 and length 3 give (0,0),(1,2); source mask 0b01, destination mask 0b10 and length 2 give (0,1).
- R4: The zero flag of an operation is 1 exactly when zeroing is on and the destination mask bit of its destination index is 0. Such an operation still consumes its source element.
- R5: The loop starts from the loaded step values, first moving each to its next enabled element at or above that value. On done, the final source and destination steps equal one past the last element each side emitted, or the loaded value if the loop emitted nothing. Example: steps 2 and 3, source mask 0b0101, destination mask 0b1010, length 4 give the single operation (2,3), with final steps 3 and 4.
- R6: While an operation is offered and not accepted, its valid, indices and zero flag stay unchanged.
- R7: If a loaded step is already at or above the vector length (a length of 0 included), done is asserted in the cycle after the start pulse and no operation is offered.
- R8: A start pulse while a loop is running has no effect on that loop.
- R9: After reset the block is idle: no operation offered, no done, not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Loads the loop parameters when idle |
| vl_i | input | IDXW | Vector length, at most MAXVL |
| src_step_i | input | IDXW | Starting source step |
| dst_step_i | input | IDXW | Starting destination step |
| src_mask_i | input | MAXVL | Source predicate, bit i for element i |
| dst_mask_i | input | MAXVL | Destination predicate, bit i for element i |
| dst_zero_i | input | 1 | Destination zeroing enable |
| op_valid_o | output | 1 | An element operation is offered |
| op_ready_i | input | 1 | Consumer accepts the offered operation |
| op_src_o | output | IDXW | Source element index |
| op_dst_o | output | IDXW | Destination element index |
| op_zero_o | output | 1 | Store zero instead of the result |
| done_o | output | 1 | One-cycle end-of-loop pulse |
| fin_src_o | output | IDXW | Final source step, valid with done |
| fin_dst_o | output | IDXW | Final destination step, valid with done |
| busy_o | output | 1 | A loop is running |

## Verification
The functions that can coincide are a stalled element offer and a new start request: while the consumer holds ready low, the sequencer must keep its offer frozen and also refuse the start pulse. The bench drives a pseudo-random ready pattern through a full 64-element loop and injects a start with different parameters in the middle of it, so the start lands on stalled and accepting cycles alike. It judges the outcome by comparing every accepted operation against an independently computed list and by checking the frozen offer on every stalled cycle, so a loop that restarted or moved under a stall shows up as a mismatch.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tps_state_e;
endpackage

// File: rtl/tps_finder.sv
// Returns the lowest set bit of mask at or above 'from'; N when none exists.
module tps_finder #(
  parameter int N = 64,
  parameter int W = 7
) (
  input  logic [N-1:0] mask,
  input  logic [W-1:0] from,
  output logic [W-1:0] idx
);
  localparam logic [W-1:0] NONE = W'(N);

  always_comb begin
    idx = NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && (W'(i) >= from)) idx = W'(i);
    end
  end
endmodule

// File: rtl/tps_lane.sv
// One step counter with its own predicate. raw_q is the search origin;
// eff_o is the enabled element the lane currently points at.
module tps_lane #(
  parameter int N = 64,
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] step_i,
  input  logic [N-1:0] mask_i,
  input  logic         all_i,
  output logic [W-1:0] eff_o,
  output logic [W-1:0] raw_o,
  output logic         bit_o
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0] raw_q, raw_d;
  logic [N-1:0] mask_q, mask_d;
  logic         all_q, all_d;
  logic         en;
  logic [N-1:0] find_mask;

  assign find_mask = all_q ? {N{1'b1}} : mask_q;

  tps_finder #(.N(N), .W(W)) u_find (
    .mask (find_mask),
    .from (raw_q),
    .idx  (eff_o)
  );

  always_comb begin
    en     = load_i | adv_i;
    raw_d  = raw_q;
    mask_d = mask_q;
    all_d  = all_q;
    if (load_i) begin
      raw_d  = step_i;
      mask_d = mask_i;
      all_d  = all_i;
    end else if (adv_i) begin
      raw_d  = eff_o + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      all_q  <= 1'b0;
    end else if (en) begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      all_q  <= all_d;
    end
  end

  assign raw_o = raw_q;
  assign bit_o = (eff_o < W'(N)) ? mask_q[eff_o[SW-1:0]] : 1'b0;
endmodule

// File: rtl/twinpred_seq.sv
module twinpred_seq #(
  parameter int MAXVL = 64,
  parameter int IDXW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDXW-1:0]  vl_i,
  input  logic [IDXW-1:0]  src_step_i,
  input  logic [IDXW-1:0]  dst_step_i,
  input  logic [MAXVL-1:0] src_mask_i,
  input  logic [MAXVL-1:0] dst_mask_i,
  input  logic             dst_zero_i,
  output logic             op_valid_o,
  input  logic             op_ready_i,
  output logic [IDXW-1:0]  op_src_o,
  output logic [IDXW-1:0]  op_dst_o,
  output logic             op_zero_o,
  output logic             done_o,
  output logic [IDXW-1:0]  fin_src_o,
  output logic [IDXW-1:0]  fin_dst_o,
  output logic             busy_o
);
  import tps_pkg::*;

  tps_state_e      st_q, st_d;
  logic [IDXW-1:0] vl_q, vl_d;
  logic            zero_q, zero_d;
  logic            load, fire, exhausted;
  logic [IDXW-1:0] src_eff, dst_eff, src_raw, dst_raw;
  logic            src_bit, dst_bit;

  tps_lane #(.N(MAXVL), .W(IDXW)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .adv_i  (fire),
    .step_i (src_step_i),
    .mask_i (src_mask_i),
    .all_i  (1'b0),
    .eff_o  (src_eff),
    .raw_o  (src_raw),
    .bit_o  (src_bit)
  );

  tps_lane #(.N(MAXVL), .W(IDXW)) u_dst (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .adv_i  (fire),
    .step_i (dst_step_i),
    .mask_i (dst_mask_i),
    .all_i  (dst_zero_i),
    .eff_o  (dst_eff),
    .raw_o  (dst_raw),
    .bit_o  (dst_bit)
  );

  always_comb begin
    load      = start_i && (st_q == ST_IDLE);
    exhausted = (src_eff >= vl_q) || (dst_eff >= vl_q);
    fire      = (st_q == ST_RUN) && !exhausted && op_ready_i;
    st_d      = st_q;
    vl_d      = vl_q;
    zero_d    = zero_q;
    case (st_q)
      ST_IDLE: if (load) begin
        st_d   = ST_RUN;
        vl_d   = vl_i;
        zero_d = dst_zero_i;
      end
      ST_RUN:  if (exhausted) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      vl_q   <= '0;
      zero_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        vl_q   <= vl_d;
        zero_q <= zero_d;
      end
    end
  end

  assign busy_o     = (st_q == ST_RUN);
  assign op_valid_o = busy_o && !exhausted;
  assign done_o     = busy_o && exhausted;
  assign op_src_o   = src_eff;
  assign op_dst_o   = dst_eff;
  assign op_zero_o  = zero_q && !dst_bit;
  assign fin_src_o  = src_raw;
  assign fin_dst_o  = dst_raw;
endmodule

// File: rtl/twinpred_seq_chk.sv
module twinpred_seq_chk #(
  parameter int IDXW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid_o,
  input logic            op_ready_i,
  input logic [IDXW-1:0] op_src_o,
  input logic [IDXW-1:0] op_dst_o,
  input logic            op_zero_o,
  input logic            done_o,
  input logic            busy_o,
  input logic [IDXW-1:0] vl_q,
  input logic            zero_q,
  input logic            src_bit,
  input logic            dst_bit
);
  // R1: offered source element is enabled in the source lane
  p_src_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> src_bit);

  // R1: source indices climb after each accepted operation
  p_src_climbs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && op_ready_i) |=> (!op_valid_o || (op_src_o > $past(op_src_o))));

  // R2: without zeroing, offered destination element is enabled
  p_dst_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && !zero_q) |-> dst_bit);

  // R3: offered indices lie below the vector length
  p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> ((op_src_o < vl_q) && (op_dst_o < vl_q)));

  // R6: a stalled offer holds still
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_o && !op_ready_i) |=>
      (op_valid_o && $stable(op_src_o) && $stable(op_dst_o) && $stable(op_zero_o)));

  // R7: done lasts one cycle and returns the block to idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

bind twinpred_seq twinpred_seq_chk #(.IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid_o (op_valid_o),
  .op_ready_i (op_ready_i),
  .op_src_o   (op_src_o),
  .op_dst_o   (op_dst_o),
  .op_zero_o  (op_zero_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .vl_q       (vl_q),
  .zero_q     (zero_q),
  .src_bit    (src_bit),
  .dst_bit    (dst_bit)
);

// File: tb/sim_twinpred_seq.sv
module sim_twinpred_seq;
  localparam int MAXVL = 64;
  localparam int IDXW  = 7;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [IDXW-1:0]  vl_i, src_step_i, dst_step_i;
  logic [MAXVL-1:0] src_mask_i, dst_mask_i;
  logic             dst_zero_i;
  logic             op_valid_o, op_ready_i, op_zero_o, done_o, busy_o;
  logic [IDXW-1:0]  op_src_o, op_dst_o, fin_src_o, fin_dst_o;

  twinpred_seq #(.MAXVL(MAXVL)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .src_step_i(src_step_i), .dst_step_i(dst_step_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i), .dst_zero_i(dst_zero_i),
    .op_valid_o(op_valid_o), .op_ready_i(op_ready_i),
    .op_src_o(op_src_o), .op_dst_o(op_dst_o), .op_zero_o(op_zero_o),
    .done_o(done_o), .fin_src_o(fin_src_o), .fin_dst_o(fin_dst_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expected item: {zero, src, dst}
  logic [2*IDXW:0] exp_q [$];
  int   exp_fs, exp_fd, exp_n;
  int   ops_seen, dones_seen, done_cyc, start_cyc;
  logic rnd_ready;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fnd(input logic [63:0] m, input int from);
    for (int i = from; i < 64; i++) if (m[i]) return i;
    return 64;
  endfunction

  // ready driver
  initial begin
    op_ready_i = 1'b1;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op_ready_i = rnd_ready ? lfsr[0] : 1'b1;
    end
  end

  // monitor
  logic            stall_prev = 1'b0;
  logic [2*IDXW:0] held;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall_prev)
          check(op_valid_o && ({op_zero_o, op_src_o, op_dst_o} == held), "R6",
                "held offer", {op_valid_o, op_zero_o, op_src_o, op_dst_o},
                {1'b1, held});
        stall_prev = op_valid_o && !op_ready_i;
        held = {op_zero_o, op_src_o, op_dst_o};
        if (op_valid_o && op_ready_i) begin
          ops_seen++;
          if (exp_q.size() == 0)
            check(1'b0, "R3", "extra op src/dst", {op_src_o, op_dst_o}, -1);
          else begin
            logic [2*IDXW:0] e;
            e = exp_q.pop_front();
            check(e == {op_zero_o, op_src_o, op_dst_o}, "R1/R2/R4",
                  "op {zero,src,dst}", {op_zero_o, op_src_o, op_dst_o}, e);
          end
        end
        if (done_o) begin
          dones_seen++;
          done_cyc = cyc;
          check(fin_src_o == IDXW'(exp_fs), "R5", "final src step", fin_src_o, exp_fs);
          check(fin_dst_o == IDXW'(exp_fd), "R5", "final dst step", fin_dst_o, exp_fd);
        end
      end
    end
  end

  // driver: builds the expected stream, starts the loop, waits for done
  task automatic run_case(input string name, input int vl, input int ss,
                          input int ds, input logic [63:0] sm,
                          input logic [63:0] dm, input bit z,
                          input bit poke, input bit expect_now);
    int sr = ss, dr = ds, s, d, d0;
    logic [63:0] dme;
    dme = z ? {64{1'b1}} : dm;
    exp_n = 0;
    forever begin
      s = fnd(sm, sr);
      d = fnd(dme, dr);
      if (s >= vl || d >= vl) break;
      exp_q.push_back({(z && !dm[d]), IDXW'(s), IDXW'(d)});
      exp_n++;
      sr = s + 1;
      dr = d + 1;
    end
    exp_fs = sr; exp_fd = dr;
    ops_seen = 0;
    d0 = dones_seen;
    @(posedge clk); #2;
    vl_i = IDXW'(vl); src_step_i = IDXW'(ss); dst_step_i = IDXW'(ds);
    src_mask_i = sm; dst_mask_i = dm; dst_zero_i = z; start_i = 1'b1;
    start_cyc = cyc;
    @(posedge clk); #2;
    start_i = 1'b0;
    if (poke) begin
      repeat (6) @(posedge clk);
      #2;
      // R8: a fresh request in mid-loop with other parameters
      vl_i = 7'd1; src_step_i = 7'd0; dst_step_i = 7'd0;
      src_mask_i = '1; dst_mask_i = '1; dst_zero_i = 1'b1; start_i = 1'b1;
      repeat (5) @(posedge clk);
      #2;
      start_i = 1'b0;
    end
    for (int t = 0; t < 2000 && dones_seen == d0; t++) @(posedge clk);
    if (dones_seen == d0) check(1'b0, "R3", {name, " no done"}, 0, 1);
    @(negedge clk);
    check(ops_seen == exp_n, poke ? "R8" : "R3", {name, " op count"}, ops_seen, exp_n);
    check(exp_q.size() == 0, "R3", {name, " leftover ops"}, exp_q.size(), 0);
    if (expect_now)
      check(done_cyc == start_cyc + 1, "R7", {name, " done latency"},
            done_cyc - start_cyc, 1);
    exp_q.delete();
    repeat (2) @(posedge clk);
  endtask

  // watchdog
  initial begin
    #3000000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rnd_ready = 1'b0;
    vl_i = '0; src_step_i = '0; dst_step_i = '0;
    src_mask_i = '0; dst_mask_i = '0; dst_zero_i = 1'b0;
    ops_seen = 0; dones_seen = 0; done_cyc = 0; start_cyc = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!op_valid_o && !done_o && !busy_o, "R9", "idle after reset",
          {op_valid_o, done_o, busy_o}, 0);

    // R3 compress / expand / twin remap
    run_case("compress", 3, 0, 0, 64'b101, '1, 1'b0, 1'b0, 1'b0);
    run_case("expand",   3, 0, 0, '1, 64'b101, 1'b0, 1'b0, 1'b0);
    run_case("twin",     2, 0, 0, 64'b01, 64'b10, 1'b0, 1'b0, 1'b0);
    // R4 zeroing keeps masked destinations
    run_case("zeroing",  2, 0, 0, '1, 64'b01, 1'b1, 1'b0, 1'b0);
    run_case("zero_sparse_src", 6, 0, 0, 64'b101101, 64'b010011, 1'b1, 1'b0, 1'b0);
    // R5 resume from preloaded steps
    run_case("resume",   4, 2, 3, 64'b0101, 64'b1010, 1'b0, 1'b0, 1'b0);
    run_case("resume_z", 8, 5, 1, 64'hFF, 64'h0F, 1'b1, 1'b0, 1'b0);
    // R7 immediate completion
    run_case("past_end", 4, 5, 0, '1, '1, 1'b0, 1'b0, 1'b1);
    run_case("dst_at_vl", 4, 0, 4, '1, '1, 1'b0, 1'b0, 1'b1);
    run_case("vl_zero",  0, 0, 0, '1, '1, 1'b0, 1'b0, 1'b1);
    run_case("empty_src", 5, 0, 0, 64'b0, '1, 1'b0, 1'b0, 1'b1);
    // R6 and R8: full-length loop, random ready, start poked mid-loop
    rnd_ready = 1'b1;
    run_case("full_poke", 64, 0, 0, '1, '1, 1'b0, 1'b1, 1'b0);
    // R1/R2 random patterns
    for (int k = 0; k < 12; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run_case("random", 1 + ($urandom % 64), $urandom % 8, $urandom % 8,
               a, b, k[0], 1'b0, 1'b0);
    end
    rnd_ready = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule